// File: doc/BRIEF.md
# Routed System Interrupt Distributor

This block is the system-wide half of a multiprocessor interrupt controller. Thirty-two device interrupt lines come in. Each line sets or clears a bit in a pending register as it rises or falls. A disable register gates each bit, and its top bit switches off all hard delivery at once. A fixed table folds every source onto a processor interrupt level from 1 to 15. The levels that survive the gating are merged into a 16-bit level vector. That vector goes to exactly one CPU, chosen by a programmable target field.

Software reaches the block over a 32-bit word-addressed bus with separate read and write strobes. The register index is the byte address shifted right by two. Enabling and disabling use two separate write ports, so single bits change without a read-modify-write. Disabling a source also drops its pending bit. A second 16-bit vector, built from the raw pending bits with no disable applied, goes to the target CPU. The per-CPU block uses it to show which hard levels are waiting.

Top module: `sysirq_router`

## Requirements
- R1: After reset, pending is 0, the target is 0, and the disable register holds 0x0FA2007F, so a read of index 1 returns 0. Every output vector is 0.
- R2: A read uses index = byte address >> 2. Index 0 returns pending with bit 31 forced to 0. Index 1 returns disable AND 0xF05DFF80. Index 4 returns the target in bits 3:0 with zeros above. Any other index returns 0. Read data appears on the clock edge that samples the read strobe, is held until the next read, and reflects state from before any write in that same cycle.
- R3: A rising source line sets its pending bit and a falling one clears it. A line that holds steady leaves the bit alone. Sources 23, 24, 25, 26 and 31 map to level 0 and never become pending.
- R4: A write to index 2 clears the disable bits selected by (data AND 0xF05DFF80). Bits outside that mask stay disabled for good.
- R5: A write to index 3 sets the disable bits selected by (data AND 0xF05DFF80) and clears the same pending bits. Such a bit stays clear until its source falls and rises again. When a source rises in the same cycle, the clear wins.
- R6: A write to index 4 stores data bits 3:0 as the target number. A target with no matching CPU sends nothing to any CPU.
- R7: Source-to-level map, by source bit: 0,7→2; 1,8→3; 2,9→5; 3,10→7; 4,11,21→9; 5,12,22→11; 6,13,17→13; 14,15→12; 16→6; 18→4; 19→10; 20→8; 27–30→15. Bit k of a level vector stands for level k, and bit 0 is always 0.
- R8: The target CPU's hard level vector has bit L set for each level L reached by a bit of (pending AND NOT disable). Every other CPU's vector is 0.
- R9: While disable bit 31 is set, every hard level vector is 0.
- R10: The target CPU's display vector has bit L set for each level L reached by any pending bit, whatever the disables. Every other CPU's display vector is 0.
- R11: Both output vectors reflect a source change or register write on the same clock edge that samples it, with no further delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | 32 | Device interrupt lines, level-sensitive |
| bus_addr | input | ADDR_W | Byte address; bits 1:0 ignored |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| cpu_irl_o | output | NUM_CPU*16 | Hard level vector per CPU, CPU c at bits 16c+15:16c |
| cpu_hard_o | output | NUM_CPU*16 | Display level vector per CPU, same layout |

## Verification
The bench builds the block with NUM_CPU = 4 and ADDR_W = 5. The 4-bit target field can then name CPUs that do not exist, which exercises delivery going nowhere while the target still reads back. The 5-bit address reaches the unused indices 5 to 7 and puts junk in the two low address bits. With four CPUs the bench can also check every output slice on every cycle and confirm that only the target slice is ever nonzero.

// File: rtl/sysirq_pkg.sv
package sysirq_pkg;
  localparam int SRC_N  = 32;
  localparam int LVL_N  = 16;
  localparam int LVL_W  = 4;
  localparam int TGT_W  = 4;
  localparam int DATA_W = 32;
  localparam int MASTER_BIT = 31;

  // writable disable bits; the rest are stuck disabled
  localparam logic [DATA_W-1:0] WR_MASK  = 32'hF05D_FF80;
  localparam logic [DATA_W-1:0] DIS_INIT = ~WR_MASK;

  // register indices (byte address >> 2)
  localparam int IDX_PEND   = 0;
  localparam int IDX_DIS    = 1;
  localparam int IDX_ENABLE = 2;
  localparam int IDX_MASK   = 3;
  localparam int IDX_TGT    = 4;

  function automatic logic [LVL_W-1:0] src_level(input int unsigned b);
    case (b)
      0, 7:          return 4'd2;
      1, 8:          return 4'd3;
      2, 9:          return 4'd5;
      3, 10:         return 4'd7;
      4, 11, 21:     return 4'd9;
      5, 12, 22:     return 4'd11;
      6, 13, 17:     return 4'd13;
      14, 15:        return 4'd12;
      16:            return 4'd6;
      18:            return 4'd4;
      19:            return 4'd10;
      20:            return 4'd8;
      27, 28, 29, 30: return 4'd15;
      default:       return 4'd0;
    endcase
  endfunction

  function automatic logic [SRC_N-1:0] level_sources(input int unsigned lvl);
    logic [SRC_N-1:0] m;
    m = '0;
    for (int b = 0; b < SRC_N; b++)
      m[b] = (src_level(b) == LVL_W'(lvl)) && (lvl != 0);
    return m;
  endfunction

  function automatic logic [SRC_N-1:0] mapped_sources();
    logic [SRC_N-1:0] m;
    m = '0;
    for (int b = 0; b < SRC_N; b++)
      m[b] = (src_level(b) != '0);
    return m;
  endfunction
endpackage

// File: rtl/sysirq_fold.sv
module sysirq_fold
  import sysirq_pkg::*;
(
  input  logic [SRC_N-1:0] bits_i,
  output logic [LVL_N-1:0] lvl_o
);
  assign lvl_o[0] = 1'b0;
  for (genvar l = 1; l < LVL_N; l++) begin : g_lvl
    localparam logic [SRC_N-1:0] SEL = level_sources(l);
    assign lvl_o[l] = |(bits_i & SEL);
  end
endmodule

// File: rtl/sysirq_regs.sv
module sysirq_regs
  import sysirq_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SRC_N-1:0]  src_i,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [SRC_N-1:0]  pend_nx,
  output logic [DATA_W-1:0] dis_nx,
  output logic [TGT_W-1:0]  tgt_nx,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int IDX_W = ADDR_W - 2;
  localparam logic [SRC_N-1:0] MAPPED = mapped_sources();

  logic [IDX_W-1:0]  idx;
  logic [SRC_N-1:0]  pend_q, src_q, rise, fall, bus_clr;
  logic [DATA_W-1:0] dis_q, sel, rd_val, rdata_q, rdata_d;
  logic [TGT_W-1:0]  tgt_q;
  logic              wr_en, wr_mask, wr_tgt;

  assign idx     = bus_addr[ADDR_W-1:2];
  assign sel     = bus_wdata & WR_MASK;
  assign wr_en   = bus_wr && (idx == IDX_W'(IDX_ENABLE));
  assign wr_mask = bus_wr && (idx == IDX_W'(IDX_MASK));
  assign wr_tgt  = bus_wr && (idx == IDX_W'(IDX_TGT));

  // pending follows source edges; a bus mask write wins over a rise
  always_comb begin
    rise    = src_i & ~src_q;
    fall    = ~src_i & src_q;
    bus_clr = wr_mask ? sel[SRC_N-1:0] : '0;
    pend_nx = (pend_q | rise) & ~fall & ~bus_clr & MAPPED;
  end

  always_comb begin
    dis_nx = dis_q;
    if (wr_en)   dis_nx = dis_q & ~sel;
    if (wr_mask) dis_nx = dis_q | sel;
    tgt_nx = wr_tgt ? bus_wdata[TGT_W-1:0] : tgt_q;
  end

  always_comb begin
    if (idx == IDX_W'(IDX_PEND))
      rd_val = DATA_W'(pend_q) & ~(DATA_W'(1) << MASTER_BIT);
    else if (idx == IDX_W'(IDX_DIS))
      rd_val = dis_q & WR_MASK;
    else if (idx == IDX_W'(IDX_TGT))
      rd_val = {{(DATA_W-TGT_W){1'b0}}, tgt_q};
    else
      rd_val = '0;
    rdata_d = bus_rd ? rd_val : rdata_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q  <= '0;
      src_q   <= '0;
      dis_q   <= DIS_INIT;
      tgt_q   <= '0;
      rdata_q <= '0;
    end else begin
      pend_q  <= pend_nx;
      src_q   <= src_i;
      dis_q   <= dis_nx;
      tgt_q   <= tgt_nx;
      rdata_q <= rdata_d;
    end
  end

  assign rdata_o = rdata_q;

  // R5: masked sources lose their pending bit
  a_r5_mask_drops_pending: assert property (@(posedge clk) disable iff (!rst_n)
    wr_mask |=> ((pend_q & $past(sel[SRC_N-1:0])) == '0));

  // R4: enable write frees the selected bits
  a_r4_enable_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_mask) |=> ((dis_q & $past(sel)) == '0));

  // R6: target takes the low nibble
  a_r6_target_nibble: assert property (@(posedge clk) disable iff (!rst_n)
    wr_tgt |=> (tgt_q == $past(bus_wdata[TGT_W-1:0])));

  // R4: stuck-disabled bits never open
  a_r4_stuck_bits: assert property (@(posedge clk) disable iff (!rst_n)
    ((dis_q & ~WR_MASK) == DIS_INIT));
endmodule

// File: rtl/sysirq_route.sv
module sysirq_route
  import sysirq_pkg::*;
#(
  parameter int NUM_CPU = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [TGT_W-1:0]         tgt_i,
  input  logic                     deliver_i,
  input  logic [LVL_N-1:0]         hard_vec_i,
  input  logic [LVL_N-1:0]         disp_vec_i,
  output logic [NUM_CPU*LVL_N-1:0] irl_o,
  output logic [NUM_CPU*LVL_N-1:0] disp_o
);
  logic [NUM_CPU*LVL_N-1:0] irl_d, disp_d, irl_q, disp_q;
  logic [NUM_CPU-1:0]       busy;

  for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
    logic hit;
    assign hit = (tgt_i == TGT_W'(c));
    always_comb begin
      irl_d[c*LVL_N +: LVL_N]  = (hit && deliver_i) ? hard_vec_i : '0;
      disp_d[c*LVL_N +: LVL_N] = hit ? disp_vec_i : '0;
    end
    assign busy[c] = |irl_q[c*LVL_N +: LVL_N];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irl_q  <= '0;
      disp_q <= '0;
    end else begin
      irl_q  <= irl_d;
      disp_q <= disp_d;
    end
  end

  assign irl_o  = irl_q;
  assign disp_o = disp_q;

  // R8: at most one CPU receives hard levels
  a_r8_single_target: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(busy));
endmodule

// File: rtl/sysirq_router.sv
module sysirq_router
  import sysirq_pkg::*;
#(
  parameter int NUM_CPU = 16,
  parameter int ADDR_W  = 5
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [31:0]              src_i,
  input  logic [ADDR_W-1:0]        bus_addr,
  input  logic                     bus_wr,
  input  logic                     bus_rd,
  input  logic [31:0]              bus_wdata,
  output logic [31:0]              bus_rdata,
  output logic [NUM_CPU*16-1:0]    cpu_irl_o,
  output logic [NUM_CPU*16-1:0]    cpu_hard_o
);
  logic [SRC_N-1:0]  pend_nx, live;
  logic [DATA_W-1:0] dis_nx;
  logic [TGT_W-1:0]  tgt_nx;
  logic [LVL_N-1:0]  hard_vec, disp_vec;
  logic              deliver;

  sysirq_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .src_i(src_i),
    .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
    .pend_nx(pend_nx), .dis_nx(dis_nx), .tgt_nx(tgt_nx), .rdata_o(bus_rdata)
  );

  assign live    = pend_nx & ~dis_nx[SRC_N-1:0];
  assign deliver = (|live) && !dis_nx[MASTER_BIT];

  sysirq_fold u_fold_live (.bits_i(live),    .lvl_o(hard_vec));
  sysirq_fold u_fold_raw  (.bits_i(pend_nx), .lvl_o(disp_vec));

  sysirq_route #(.NUM_CPU(NUM_CPU)) u_route (
    .clk(clk), .rst_n(rst_n), .tgt_i(tgt_nx), .deliver_i(deliver),
    .hard_vec_i(hard_vec), .disp_vec_i(disp_vec),
    .irl_o(cpu_irl_o), .disp_o(cpu_hard_o)
  );

  // R9: setting the master bit silences all hard delivery
  a_r9_master_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr[ADDR_W-1:2] == (ADDR_W-2)'(IDX_MASK) && bus_wdata[MASTER_BIT])
    |=> (cpu_irl_o == '0));

  // R7: level 0 is never signalled
  a_r7_no_level0: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_irl_o[0] == 1'b0) && (cpu_hard_o[0] == 1'b0));
endmodule

// File: tb/tb_sysirq_router.sv
module tb_sysirq_router;
  localparam int NC = 4;
  localparam int AW = 5;
  localparam logic [31:0] VM = 32'hF05DFF80;

  logic clk, rst_n, wr, rd;
  logic [31:0] src, wdata, rdata;
  logic [AW-1:0] addr;
  logic [NC*16-1:0] irl, hard;

  sysirq_router #(.NUM_CPU(NC), .ADDR_W(AW)) dut (
    .clk(clk), .rst_n(rst_n), .src_i(src), .bus_addr(addr), .bus_wr(wr),
    .bus_rd(rd), .bus_wdata(wdata), .bus_rdata(rdata),
    .cpu_irl_o(irl), .cpu_hard_o(hard)
  );

  initial clk = 0;
  always #2 clk = ~clk;

  int checks = 0, errors = 0;
  bit done = 0;
  int tbl [32] = '{2,3,5,7,9,11,13,2,3,5,7,9,11,13,12,12,
                   6,13,4,10,8,9,11,0,0,0,0,15,15,15,15,0};
  logic [31:0] m_pend, m_dis, m_sprev, m_rdata;
  logic [3:0]  m_tgt;

  function automatic logic [15:0] fold(input logic [31:0] v);
    logic [15:0] r = '0;
    for (int b = 0; b < 32; b++) if (v[b] && tbl[b] != 0) r[tbl[b]] = 1'b1;
    return r;
  endfunction

  function automatic logic [31:0] mapped();
    logic [31:0] r = '0;
    for (int b = 0; b < 32; b++) r[b] = (tbl[b] != 0);
    return r;
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    logic [31:0] npend, ndis, clr, eff;
    logic [3:0] ntgt;
    int idx;
    idx = int'(addr) >> 2;
    if (rd) begin
      case (idx)
        0: m_rdata = m_pend & 32'h7FFFFFFF;
        1: m_rdata = m_dis & VM;
        4: m_rdata = {28'd0, m_tgt};
        default: m_rdata = 32'd0;
      endcase
    end
    clr = (wr && idx == 3) ? (wdata & VM) : 32'd0;
    npend = ((m_pend | (src & ~m_sprev)) & ~(~src & m_sprev)) & ~clr & mapped();
    ndis = m_dis;
    if (wr && idx == 2) ndis = m_dis & ~(wdata & VM);
    if (wr && idx == 3) ndis = m_dis | (wdata & VM);
    ntgt = (wr && idx == 4) ? wdata[3:0] : m_tgt;
    @(posedge clk); @(negedge clk);
    m_pend = npend; m_dis = ndis; m_tgt = ntgt; m_sprev = src;
    eff = m_pend & ~m_dis;
    for (int c = 0; c < NC; c++) begin
      logic [15:0] ei, eh;
      ei = (m_tgt == c && eff != 0 && !m_dis[31]) ? fold(eff) : 16'd0;
      eh = (m_tgt == c) ? fold(m_pend) : 16'd0;
      chk("R8 hard levels", 64'(irl[c*16 +: 16]), 64'(ei));
      chk("R10 display levels", 64'(hard[c*16 +: 16]), 64'(eh));
    end
    chk("R2 read data", 64'(rdata), 64'(m_rdata));
    wr = 0; rd = 0;
  endtask

  task automatic wreg(input int idx, input logic [31:0] d);
    addr = AW'(idx << 2); wdata = d; wr = 1; step();
  endtask

  task automatic rreg(input int idx, output logic [31:0] d);
    addr = AW'(idx << 2); rd = 1; step(); d = rdata;
  endtask

  initial begin
    #(4 * 190000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'h1234_5EED));
    src = 0; wr = 0; rd = 0; addr = 0; wdata = 0; rst_n = 0;
    m_pend = 0; m_dis = 32'h0FA2007F; m_tgt = 0; m_sprev = 0; m_rdata = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 irl at reset", 64'(irl), 64'd0);
    chk("R1 display at reset", 64'(hard), 64'd0);
    rreg(0, d); chk("R1 pending reset", 64'(d), 64'd0);
    rreg(1, d); chk("R1 disable reads 0", 64'(d), 64'd0);
    rreg(4, d); chk("R1 target reset", 64'(d), 64'd0);

    // R7: walk every source alone
    for (int b = 0; b < 32; b++) begin
      src = 32'd1 << b; step();
      chk("R7 map display", 64'(hard[15:0]), 64'(tbl[b] != 0 ? (16'd1 << tbl[b]) : 16'd0));
      src = 0; step();
    end

    // R11: change visible on the sampling edge
    src = 32'd1 << 14;
    chk("R11 before edge", 64'(irl[15:0]), 64'd0);
    step();
    chk("R11 after edge", 64'(irl[15:0]), 64'(16'd1 << 12));
    src = 0; step();

    // R3: unmapped lines never pend
    src = 32'h8780_0000; step();
    rreg(0, d); chk("R3 unmapped stay clear", 64'(d), 64'd0);
    src = 0; step();

    // R5: mask drops pending; stays clear until a new rise
    src = 32'd1 << 7; step();
    wreg(3, 32'd1 << 7);
    wreg(2, 32'd1 << 7);
    rreg(0, d); chk("R5 pending stays dropped", 64'(d[7]), 64'd0);
    chk("R5 no delivery after re-enable", 64'(irl[15:0]), 64'd0);
    src = 0; step(); src = 32'd1 << 7; step();
    chk("R5 new rise delivers", 64'(irl[15:0]), 64'(16'd1 << 2));
    // R5: same-cycle rise and mask
    src = src | (32'd1 << 8); addr = AW'(3 << 2); wdata = 32'd1 << 8; wr = 1; step();
    rreg(0, d); chk("R5 bus clear wins", 64'(d[8]), 64'd0);
    wreg(2, 32'd1 << 8);
    // R4: stuck bits 0..6 remain disabled
    src = src | 32'd1; step();
    wreg(2, 32'hFFFFFFFF);
    rreg(1, d); chk("R4 enable all", 64'(d), 64'd0);
    chk("R4 stuck source blocked", 64'(irl[15:0]), 64'(16'd1 << 2));

    // R9: master disable
    wreg(3, 32'h8000_0000);
    chk("R9 master blocks", 64'(irl), 64'd0);
    chk("R10 display ignores master", 64'(hard[15:0]), 64'((16'd1 << 2) | (16'd1 << 2)));
    wreg(2, 32'h8000_0000);
    chk("R9 master cleared", 64'(irl[15:0]), 64'(16'd1 << 2));

    // R6: target selection
    wreg(4, 32'hFFFF_FFF3);
    rreg(4, d); chk("R6 low nibble", 64'(d), 64'd3);
    chk("R6 routed to cpu3", 64'(irl[63:48]), 64'(16'd1 << 2));
    wreg(4, 32'd9);
    chk("R6 absent target", 64'(irl), 64'd0);
    rreg(4, d); chk("R6 target readback", 64'(d), 64'd9);
    // R2: unused index and odd byte address
    rreg(5, d); chk("R2 unused index", 64'(d), 64'd0);
    addr = AW'(5'h11); rd = 1; step(); chk("R2 byte bits ignored", 64'(rdata), 64'd9);
    wreg(4, 32'd0);

    // random traffic
    for (int n = 0; n < 4000; n++) begin
      int op;
      src = src ^ ($urandom & $urandom & $urandom);
      op = int'($urandom % 8);
      addr = AW'($urandom);
      case (op)
        0: begin addr = AW'((2 << 2) | ($urandom % 4)); wdata = $urandom; wr = 1; end
        1: begin addr = AW'((3 << 2) | ($urandom % 4)); wdata = $urandom & $urandom & $urandom; wr = 1; end
        2: begin addr = AW'(4 << 2); wdata = $urandom % 6; wr = 1; end
        3: rd = 1;
        default: ;
      endcase
      step();
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule